// File: doc/BRIEF.md
# Selectable-Length Bit-Stream Scrambler

This block whitens a serial payload. Each payload bit is XORed with the output bit of a pseudo-random generator. A two-bit length field selects the generator: a short 6-stage shift register, a long 15-stage shift register, or no scrambling at all. Each generator is seeded from two configuration bytes. The long generator takes its seed from both bytes. The short generator takes its seed from a subset of the upper byte only.

A packet-start strobe reloads the seed, so every packet is whitened with the same mask sequence. The bit stream moves through a valid/ready pair and is not buffered. The generator advances only on bits that are actually accepted, so back-pressure never costs mask bits.

A separate placement bit says whether the scrambler sits ahead of or behind an external block-encoder stage. The block passes that choice out unchanged to the datapath multiplexers that build the chain.

Top module: `pkt_scrambler`

## Requirements
- R1: `cfg_len_sel` picks the mode. 2'b00 selects the 6-stage generator and 2'b01 selects the 15-stage generator. Both 2'b10 and 2'b11 switch scrambling off, so `out_bit` equals `in_bit`.
- R2: In 15-stage mode the seed is {`cfg_seed_hi`[6:0], `cfg_seed_lo`[7:0]}, with seed bit 14 taken from `cfg_seed_hi`[6]. `cfg_seed_hi`[7] has no effect.
- R3: In 6-stage mode seed bits 5..1 come from `cfg_seed_hi`[6:2] and seed bit 0 comes from `cfg_seed_hi`[0]. `cfg_seed_hi`[1], `cfg_seed_hi`[7] and all of `cfg_seed_lo` have no effect.
- R4: Each generator is a Fibonacci shift register of width W (6 or 15). On a step, the register shifts toward its MSB, and bit 0 takes the new value state[W-1] XOR state[W-2]. This realizes x^6+x^5+1 and x^15+x^14+1.
- R5: The mask bit is the MSB of the active generator, and `out_bit` = `in_bit` XOR mask.
- R6: When `pkt_start` is high, the seed replaces the register contents. A bit accepted in that same cycle is masked with the seed's MSB, and the generator then steps from the seed.
- R7: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. The generator steps only when `in_valid` and `out_ready` are both high. A stalled cycle leaves the sequence where it was.
- R8: `place_before_o` follows `cfg_place_before`. A value of 1 means the scrambler precedes the block encoder and 0 means it follows it.
- R9: An all-zero seed is accepted as written and gives an all-zero mask, so the data passes unchanged for the whole packet.
- R10: After reset both generators hold zero, so the mask is zero until the first `pkt_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_sel | input | 2 | Generator length / bypass select |
| cfg_seed_lo | input | 8 | Lower seed byte (long generator only) |
| cfg_seed_hi | input | 8 | Upper seed byte |
| cfg_place_before | input | 1 | Scrambler placement relative to the encoder |
| place_before_o | output | 1 | Placement choice for the external mux |
| pkt_start | input | 1 | Reloads the seed at the start of a packet |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block can accept an input bit |
| in_bit | input | 1 | Payload bit in |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Scrambled bit out |

## Verification
The bench compares every accepted bit with its own model of both generators. The model is seeded from the byte layouts above, so a swapped seed byte or a mis-mapped short seed shows up as a wrong mask bit within the first few bits.

Back-pressure stalls are placed in the middle of a packet. A generator that stepped on valid alone would then run one mask bit ahead after the stall.

A second `pkt_start` in the middle of a packet checks that the seed is reloaded. It also checks that the first bit uses the seed's MSB rather than the register's old value.

Both bypass codes, an all-zero seed, and toggling the ignored seed bits are each run. A decoder that read a don't-care bit, or that treated 2'b11 as a live mode, would produce a mask where none should exist.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic [1:0] {
      SCR_LEN_SHORT = 2'b00,
      SCR_LEN_LONG  = 2'b01,
      SCR_LEN_OFF0  = 2'b10,
      SCR_LEN_OFF1  = 2'b11
   } scr_len_e;

   localparam int unsigned SCR_BYTE_W  = 8;
   localparam int unsigned SCR_SHORT_W = 6;
   localparam int unsigned SCR_LONG_W  = 15;
endpackage

// File: rtl/scr_cfg_decode.sv
module scr_cfg_decode
   import scr_pkg::*;
#(
   parameter int unsigned BYTE_W    = SCR_BYTE_W,
   parameter int unsigned SHORT_W   = SCR_SHORT_W,
   parameter int unsigned LONG_W    = SCR_LONG_W,
   parameter int unsigned SHORT_GAP = 1
) (
   input  logic [1:0]         len_sel,
   input  logic [BYTE_W-1:0]  seed_lo,
   input  logic [BYTE_W-1:0]  seed_hi,
   output logic               use_short,
   output logic               use_long,
   output logic [SHORT_W-1:0] seed_short,
   output logic [LONG_W-1:0]  seed_long
);
   localparam int unsigned HI_USED = LONG_W - BYTE_W;

   if (LONG_W <= BYTE_W || LONG_W >= 2 * BYTE_W) begin : g_bad_long
      $error("scr_cfg_decode: LONG_W must lie strictly between BYTE_W and 2*BYTE_W");
   end
   if (SHORT_W + 1 > HI_USED || SHORT_GAP >= SHORT_W) begin : g_bad_short
      $error("scr_cfg_decode: short seed does not fit in the upper seed field");
   end

   scr_len_e len_q;
   assign len_q     = scr_len_e'(len_sel);
   assign use_short = (len_q == SCR_LEN_SHORT);
   assign use_long  = (len_q == SCR_LEN_LONG);

   assign seed_long = {seed_hi[HI_USED-1:0], seed_lo};

   for (genvar i = 0; i < SHORT_W; i++) begin : g_short_map
      localparam int unsigned SRC = (i < SHORT_GAP) ? i : i + 1;
      assign seed_short[i] = seed_hi[SRC];
   end

   logic unused_hi_top;
   assign unused_hi_top = ^seed_hi[BYTE_W-1:HI_USED];

   // R1
   always_comb begin
      decode_excl_chk: assert (!(use_short && use_long) || $isunknown(len_sel));
   end
endmodule

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
   parameter int unsigned W   = 15,
   parameter int unsigned TAP = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         adv,
   input  logic [W-1:0] seed,
   output logic         mask_bit
);
   if (W < 3) begin : g_bad_w
      $error("scr_lfsr: W must be at least 3");
   end
   if (TAP < 1 || TAP >= W) begin : g_bad_tap
      $error("scr_lfsr: TAP must lie in 1..W-1");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] cur;
   logic [W-1:0] stepped;
   logic         fb;

   assign cur      = load ? seed : state_q;
   assign fb       = cur[W-1] ^ cur[TAP-1];
   assign stepped  = {cur[W-2:0], fb};
   assign mask_bit = cur[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (adv) begin
         state_q <= stepped;
      end else if (load) begin
         state_q <= seed;
      end
   end

   // R7
   hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(state_q));

   // R6
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !adv) |=> (state_q == $past(seed)));

   // R9
   zero_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && state_q == '0) |=> (state_q == '0));
endmodule

// File: rtl/pkt_scrambler.sv
module pkt_scrambler
   import scr_pkg::*;
#(
   parameter int unsigned BYTE_W    = SCR_BYTE_W,
   parameter int unsigned SHORT_W   = SCR_SHORT_W,
   parameter int unsigned LONG_W    = SCR_LONG_W,
   parameter int unsigned SHORT_TAP = SCR_SHORT_W - 1,
   parameter int unsigned LONG_TAP  = SCR_LONG_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_len_sel,
   input  logic [BYTE_W-1:0] cfg_seed_lo,
   input  logic [BYTE_W-1:0] cfg_seed_hi,
   input  logic              cfg_place_before,
   output logic              place_before_o,
   input  logic              pkt_start,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_bit,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_bit
);
   logic               use_short;
   logic               use_long;
   logic [SHORT_W-1:0] seed_short;
   logic [LONG_W-1:0]  seed_long;
   logic               mask_short;
   logic               mask_long;
   logic               accept;
   logic               mask;

   scr_cfg_decode #(
      .BYTE_W (BYTE_W),
      .SHORT_W(SHORT_W),
      .LONG_W (LONG_W)
   ) u_dec (
      .len_sel   (cfg_len_sel),
      .seed_lo   (cfg_seed_lo),
      .seed_hi   (cfg_seed_hi),
      .use_short (use_short),
      .use_long  (use_long),
      .seed_short(seed_short),
      .seed_long (seed_long)
   );

   assign accept = in_valid && out_ready;

   scr_lfsr #(.W(SHORT_W), .TAP(SHORT_TAP)) u_gen_short (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pkt_start),
      .adv     (accept),
      .seed    (seed_short),
      .mask_bit(mask_short)
   );

   scr_lfsr #(.W(LONG_W), .TAP(LONG_TAP)) u_gen_long (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pkt_start),
      .adv     (accept),
      .seed    (seed_long),
      .mask_bit(mask_long)
   );

   always_comb begin
      mask = 1'b0;
      if (use_long) begin
         mask = mask_long;
      end else if (use_short) begin
         mask = mask_short;
      end
   end

   assign out_bit        = in_bit ^ mask;
   assign out_valid      = in_valid;
   assign in_ready       = out_ready;
   assign place_before_o = cfg_place_before;

   // R1
   bypass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_len_sel[1] |-> (out_bit == in_bit));

   // R7
   flow_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
endmodule

// File: tb/pkt_scrambler_tb_top.sv
module pkt_scrambler_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_len_sel = 2'b10;
   logic [7:0] cfg_seed_lo = '0;
   logic [7:0] cfg_seed_hi = '0;
   logic       cfg_place_before = 1'b0;
   logic       place_before_o;
   logic       pkt_start = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       in_bit = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic       out_bit;

   int n_chk = 0;
   int n_fail = 0;

   logic [14:0] m_state;
   logic [14:0] m_seed;
   int          m_w;
   bit          m_off;
   logic [31:0] lcg = 32'h1234_5678;

   always #5 clk = ~clk;

   pkt_scrambler dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_len_sel(cfg_len_sel), .cfg_seed_lo(cfg_seed_lo), .cfg_seed_hi(cfg_seed_hi),
      .cfg_place_before(cfg_place_before), .place_before_o(place_before_o),
      .pkt_start(pkt_start), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
      .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
   );

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [14:0] mstep(logic [14:0] s, int w);
      logic fb;
      logic [14:0] r;
      fb = s[w-1] ^ s[w-2];
      r  = (s << 1) | {14'd0, fb};
      r  = r & ((15'd1 << w) - 15'd1);
      return r;
   endfunction

   task automatic configure(logic [1:0] len, logic [7:0] lo, logic [7:0] hi, logic place);
      @(negedge clk);
      cfg_len_sel = len; cfg_seed_lo = lo; cfg_seed_hi = hi; cfg_place_before = place;
      m_off = len[1];
      m_w   = (len == 2'b00) ? 6 : 15;
      m_seed = (len == 2'b00) ? {9'd0, hi[6:2], hi[0]} : {hi[6:0], lo};
   endtask

   // drives one accepted bit and checks the output before the clock edge
   task automatic send_bit(logic b, logic start, string req);
      logic [14:0] cur;
      logic        exp;
      @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b1; in_bit = b; pkt_start = start;
      cur = start ? m_seed : m_state;
      exp = m_off ? b : (b ^ cur[m_w-1]);
      #1;
      check(req, out_bit, exp);
      m_state = mstep(cur, m_w);
      @(posedge clk);
      #1;
      pkt_start = 1'b0; in_valid = 1'b0;
   endtask

   task automatic send_pkt(int n, string req);
      for (int i = 0; i < n; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         send_bit(lcg[17], i == 0, req);
      end
   endtask

   task automatic t_reset();
      configure(2'b01, 8'h5A, 8'h33, 1'b1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_bit = i[0];
         #1;
         check("R10 mask zero after reset", out_bit, in_bit);
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R8 placement before", place_before_o, 1'b1);
   endtask

   task automatic t_long();
      configure(2'b01, 8'hC3, 8'h4D, 1'b0);
      check("R8 placement after", place_before_o, 1'b0);
      send_pkt(40, "R2 R4 R5 long sequence");
      configure(2'b01, 8'h01, 8'h00, 1'b0);
      send_pkt(30, "R4 long single-bit seed");
   endtask

   task automatic t_short();
      configure(2'b00, 8'h00, 8'h7D, 1'b0);
      send_pkt(40, "R3 R4 R5 short sequence");
   endtask

   task automatic t_restart();
      configure(2'b01, 8'h9E, 8'h2B, 1'b0);
      send_pkt(12, "R6 first packet");
      send_bit(1'b0, 1'b1, "R6 restart uses seed MSB");
      send_pkt(0, "R6");
      for (int i = 0; i < 10; i++) send_bit(i[1], 1'b0, "R6 restarted sequence");
   endtask

   task automatic t_stall();
      configure(2'b00, 8'h00, 8'h5F, 1'b0);
      send_pkt(7, "R7 before stall");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_valid = 1'b1; out_ready = 1'b0; in_bit = 1'b1;
         #1;
         check("R7 in_ready follows out_ready", in_ready, 1'b0);
         check("R7 out_valid follows in_valid", out_valid, 1'b1);
      end
      for (int i = 0; i < 12; i++) send_bit(i[0], 1'b0, "R7 sequence resumes after stall");
   endtask

   task automatic t_bypass();
      configure(2'b10, 8'hFF, 8'hFF, 1'b0);
      send_pkt(10, "R1 bypass code 10");
      configure(2'b11, 8'hA7, 8'h6E, 1'b1);
      send_pkt(10, "R1 bypass code 11");
   endtask

   task automatic t_dontcare();
      configure(2'b00, 8'h00, 8'b0101_1001, 1'b0);
      send_pkt(20, "R3 short base seed");
      configure(2'b00, 8'hFF, 8'b1101_1011, 1'b0);
      send_pkt(20, "R3 ignored short seed bits");
      configure(2'b01, 8'h6C, 8'h95, 1'b0);
      send_pkt(20, "R2 ignored long seed bit");
   endtask

   task automatic t_zero_seed();
      configure(2'b01, 8'h00, 8'h80, 1'b0);
      for (int i = 0; i < 20; i++) send_bit(1'b1, i == 0, "R9 zero seed long passes data");
      configure(2'b00, 8'hFF, 8'h02, 1'b0);
      for (int i = 0; i < 20; i++) send_bit(i[0], i == 0, "R9 zero seed short passes data");
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      m_state = '0; m_seed = '0; m_w = 15; m_off = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_long();
      t_short();
      t_restart();
      t_stall();
      t_bypass();
      t_dontcare();
      t_zero_seed();
      repeat (2) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule